// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Bank

This block holds four 8-bit down-counting timers. Software reaches them over a small register bus. Each transfer carries an address, a size code, write data and a valid strobe. Read data and an error flag come back in the same cycle. Each timer has three registers: a mode register, a reload (base) register and a read-only counter. A running timer counts once per cycle in which the shared `tick` input is high. It reloads from its base register when its period ends and raises a one-cycle underflow pulse.

Adjacent timers can be chained into one counter of 16, 24 or 32 bits. A timer in cascade mode takes its clock from the borrow of the timer just below it. The chain then acts as a single wide reload counter, and only its highest member reports the underflow. Access widths are limited per register so that a chain can be read or loaded in one transfer. Illegal accesses are rejected with the error flag and change no state.

Top module: `cascade_timer_bank`

## Requirements
- R1: After reset, every mode, base and counter register reads as zero, and no underflow pulse or error is signalled.
- R2: Mode bit 7 enables counting and bit 6 loads the counter from the base register. Bits 1:0 choose the clock: 00 selects the tick, 11 selects cascade from the next-lower timer. A lone timer with base B counts B, B-1, …, 1 on successive ticks, then reloads B on the next tick and pulses its underflow. Its period is therefore B ticks.
- R3: A mode write with bits 7 and 6 both set, or with any of bits 5:2 set, raises the error flag and leaves the mode register unchanged.
- R4: A mode write that selects cascade (bits 1:0 = 11) on timer 0 raises the error flag and is rejected.
- R5: A mode write that starts a non-cascaded timer is rejected with the error flag if any timer in the cascade run directly above it lacks the enable bit.
- R6: A base write to a stopped timer also loads its counter. On a running timer the counter keeps counting, and the new base is used at the next reload.
- R7: A chain runs from a non-cascaded timer h up to the last consecutive timer in cascade mode. Its reload value holds base i at bit offset 8·(i−h). Only the top member of the chain pulses its underflow.
- R8: The registers sit at offsets 0x00–0x03 (mode), 0x10–0x13 (base) and 0x20–0x23 (counter), one byte per timer. The size code gives 2^code bytes. One-byte access is legal anywhere. Two-byte access is legal only at timers 0 and 2, and four-byte access only at timer 0. Timer n sits in data bits 7:0, n+1 in 15:8, and so on. Mode writes must be one byte. Any other width raises the error flag.
- R9: The counter registers are read-only, and a write to them raises the error flag. A counter read returns the remaining count, which equals the base value while the timer is stopped.
- R10: Clearing the enable bit stops the timer at once and returns its counter to the base value. With a zero reload value an enabled timer does not count and never underflows.
- R11: An access to an unmapped offset, or with size code 3, raises the error flag. No access that raises the error flag changes any register.
- R12: An underflow pulse is high for exactly one cycle. It appears in the cycle after the clock edge that sampled the ending tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count tick for timers using the internal clock |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data, first timer in bits 7:0 |
| bus_rdata | output | 32 | Read data, same cycle, zero on error or write |
| bus_err | output | 1 | Access rejected, same cycle |
| uflow | output | 4 | Per-timer underflow pulses |

## Verification
The bench targets the 16-bit chain crossing 0x0100 → 0x00FF. A design that reloads the low byte from its base at that point, instead of wrapping it to 0xFF, produces a short period. It also checks where the chain's underflow appears: a pulse on the lower member shows the chain top was found wrongly. A base write during counting must leave the live count alone. A design that loads it at once would change the current period. Rejected writes are read back afterwards, because illegal mode values or cascade requests that leak into a register would later start timers nobody asked for. Finally, a zero reload value must not wrap the counter to 0xFF and start counting.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;

  typedef enum logic [1:0] {
    GRP_MODE = 2'd0,
    GRP_BASE = 2'd1,
    GRP_CNT  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam logic [1:0] SRC_TICK    = 2'b00;
  localparam logic [1:0] SRC_CASCADE = 2'b11;

  // Legality of one mode byte on its own (neighbours checked elsewhere).
  function automatic logic mode_byte_ok(input logic is_first, input logic [7:0] v);
    logic both, reserved, bad_casc;
    both     = v[7] & v[6];
    reserved = (v[5:2] != 4'd0);
    bad_casc = is_first && (v[1:0] == SRC_CASCADE);
    return !(both || reserved || bad_casc);
  endfunction

  // Bytes moved by one access of the given size code.
  function automatic int size_bytes(input logic [1:0] code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/tmrb_decode.sv
module tmrb_decode
  import tmrb_pkg::*;
#(
  parameter int NUM = 4,
  parameter int AW  = 8
) (
  input  logic                    valid,
  input  logic                    write,
  input  logic [AW-1:0]           addr,
  input  logic [1:0]              size,
  input  logic [7:0]              wbyte,
  input  logic [NUM*8-1:0]        mode_flat,
  output grp_e                    grp,
  output logic [$clog2(NUM)-1:0]  idx,
  output logic                    err,
  output logic [NUM-1:0]          lanes
);
  localparam int IDXW = $clog2(NUM);

  logic mapped, fits, chain_ok, open, starting, mode_ok;
  int   nb;

  always_comb begin
    grp    = grp_e'(addr[5:4]);
    idx    = addr[IDXW-1:0];
    mapped = (addr[AW-1:6] == '0) && (addr[3:IDXW] == '0) && (addr[5:4] != 2'b11);
    nb     = size_bytes(size);
    fits   = (size != 2'b11) && ((int'(idx) % nb) == 0) && ((int'(idx) + nb) <= NUM);

    // Walk the cascade run above the addressed timer.
    chain_ok = 1'b1;
    open     = 1'b1;
    for (int j = 0; j < NUM; j++) begin
      if (j > int'(idx)) begin
        if (open && (mode_flat[8*j +: 2] == SRC_CASCADE)) begin
          if (!mode_flat[8*j+7]) chain_ok = 1'b0;
        end else begin
          open = 1'b0;
        end
      end
    end

    starting = wbyte[7] && (wbyte[1:0] != SRC_CASCADE);
    mode_ok  = (size == 2'b00) && mode_byte_ok(idx == '0, wbyte) && (!starting || chain_ok);

    err = valid && (!mapped || !fits ||
                    (write && grp == GRP_CNT) ||
                    (write && grp == GRP_MODE && !mode_ok));

    for (int j = 0; j < NUM; j++)
      lanes[j] = valid && !err && (j >= int'(idx)) && (j < int'(idx) + nb);
  end

endmodule

// File: rtl/tmrb_chain.sv
module tmrb_chain
  import tmrb_pkg::*;
#(
  parameter int NUM = 4
) (
  input  logic               tick,
  input  logic [NUM*8-1:0]   mode_flat,
  input  logic [NUM*8-1:0]   cnt_flat,
  output logic [NUM-1:0]     step_ev,
  output logic [NUM-1:0]     reload_ev,
  output logic [NUM-1:0]     under_ev
);
  logic [NUM-1:0] cne, casc, top;
  logic [NUM-1:0] nz_low, one_low, zero_below;
  logic [NUM-1:0] ch_nz, ch_one, ev_head;
  logic           p_nz, p_one, p_zb, p_cz, p_ev, nxt_casc, p_chnz, p_chone;
  logic [7:0]     cv;

  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      cne[i]  = mode_flat[8*i+7];
      casc[i] = (i > 0) && (mode_flat[8*i +: 2] == SRC_CASCADE);
    end

    // Upward pass: state of the chain from its head up to each member.
    p_nz = 1'b0; p_one = 1'b0; p_zb = 1'b0; p_cz = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      cv = cnt_flat[8*i +: 8];
      if (!casc[i]) begin
        nz_low[i]     = (cv != 8'd0);
        one_low[i]    = (cv == 8'd1);
        zero_below[i] = 1'b1;
      end else begin
        nz_low[i]     = p_nz | (cv != 8'd0);
        one_low[i]    = p_one & (cv == 8'd0);
        zero_below[i] = p_zb & p_cz;
      end
      p_nz = nz_low[i]; p_one = one_low[i]; p_zb = zero_below[i]; p_cz = (cv == 8'd0);
    end

    // Downward pass: whole-chain value seen from every member.
    nxt_casc = 1'b0; p_chnz = 1'b0; p_chone = 1'b0;
    for (int i = NUM - 1; i >= 0; i--) begin
      top[i]    = (i == NUM - 1) || !nxt_casc;
      ch_nz[i]  = top[i] ? nz_low[i]  : p_chnz;
      ch_one[i] = top[i] ? one_low[i] : p_chone;
      p_chnz = ch_nz[i]; p_chone = ch_one[i]; nxt_casc = casc[i];
    end

    // Head event propagates to every member of its chain.
    p_ev = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      ev_head[i]   = casc[i] ? p_ev : (tick & cne[i] & ch_nz[i]);
      p_ev         = ev_head[i];
      step_ev[i]   = ev_head[i] & cne[i] & zero_below[i] & !ch_one[i];
      reload_ev[i] = ev_head[i] & cne[i] & ch_one[i];
      under_ev[i]  = reload_ev[i] & top[i];
    end
  end

endmodule

// File: rtl/cascade_timer_bank.sv
module cascade_timer_bank
  import tmrb_pkg::*;
#(
  parameter int NUM = 4,
  parameter int AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [AW-1:0]      bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [NUM*8-1:0]   bus_wdata,
  output logic [NUM*8-1:0]   bus_rdata,
  output logic               bus_err,
  output logic [NUM-1:0]     uflow
);
  localparam int IDXW = $clog2(NUM);
  localparam int BW   = NUM * 8;

  logic [BW-1:0]   mode_flat, base_flat, cnt_flat;
  grp_e            grp;
  logic [IDXW-1:0] idx;
  logic [NUM-1:0]  lanes;
  logic [NUM-1:0]  step_ev, reload_ev, under_ev;
  logic [BW-1:0]   wsh, gather, rsh;
  logic [NUM-1:0]  rmask;

  tmrb_decode #(.NUM(NUM), .AW(AW)) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr), .size(bus_size),
    .wbyte(bus_wdata[7:0]), .mode_flat(mode_flat),
    .grp(grp), .idx(idx), .err(bus_err), .lanes(lanes)
  );

  tmrb_chain #(.NUM(NUM)) u_chain (
    .tick(tick), .mode_flat(mode_flat), .cnt_flat(cnt_flat),
    .step_ev(step_ev), .reload_ev(reload_ev), .under_ev(under_ev)
  );

  assign wsh = bus_wdata << {idx, 3'b000};

  for (genvar i = 0; i < NUM; i++) begin : g_tmr
    logic [7:0] mode_q, base_q, cnt_q;
    logic       wr_mode, wr_base;
    logic [7:0] wb;

    assign wb      = wsh[8*i +: 8];
    assign wr_mode = lanes[i] && bus_write && (grp == GRP_MODE);
    assign wr_base = lanes[i] && bus_write && (grp == GRP_BASE);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q <= '0;
        base_q <= '0;
        cnt_q  <= '0;
      end else begin
        if (wr_mode) mode_q <= wb;
        if (wr_base) base_q <= wb;
        if (wr_mode && !wb[7])            cnt_q <= base_q;
        else if (wr_base && !mode_q[7])   cnt_q <= wb;
        else if (reload_ev[i])            cnt_q <= base_q;
        else if (step_ev[i])              cnt_q <= cnt_q - 8'd1;
      end
    end

    assign mode_flat[8*i +: 8] = mode_q;
    assign base_flat[8*i +: 8] = base_q;
    assign cnt_flat[8*i +: 8]  = cnt_q;
  end

  always_comb begin
    case (grp)
      GRP_MODE: gather = mode_flat;
      GRP_BASE: gather = base_flat;
      GRP_CNT:  gather = cnt_flat;
      default:  gather = '0;
    endcase
    rsh   = gather >> {idx, 3'b000};
    rmask = lanes >> idx;
    for (int j = 0; j < NUM; j++)
      bus_rdata[8*j +: 8] = (!bus_write && rmask[j]) ? rsh[8*j +: 8] : 8'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) uflow <= '0;
    else        uflow <= under_ev;
  end

endmodule

// File: rtl/tmrb_checker.sv
module tmrb_checker #(
  parameter int NUM = 4,
  parameter int AW  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [AW-1:0]    bus_addr,
  input logic [1:0]       bus_size,
  input logic [NUM*8-1:0] bus_wdata,
  input logic             bus_err,
  input logic [NUM-1:0]   uflow,
  input logic [NUM*8-1:0] mode_flat,
  input logic [NUM*8-1:0] base_flat,
  input logic [NUM*8-1:0] cnt_flat
);

  p_mode_illegal_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[AW-1:2] == '0 && bus_size == 2'b00 &&
     ((bus_wdata[7] && bus_wdata[6]) || bus_wdata[5:2] != 4'd0)) |-> bus_err);

  p_first_never_cascade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flat[1:0] != 2'b11);

  p_counter_write_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[AW-1:4] == 'd2) |-> bus_err);

  p_err_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_err) |=> ($stable(mode_flat) && $stable(base_flat)));

  for (genvar i = 0; i < NUM; i++) begin : g_per
    p_stopped_reads_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_flat[8*i+7] |-> (cnt_flat[8*i +: 8] == base_flat[8*i +: 8]));

    p_pulse_follows_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      uflow[i] |-> $past(tick));

    if (i < NUM - 1) begin : g_top
      p_pulse_on_top_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uflow[i] |-> $past(mode_flat[8*(i+1) +: 2] != 2'b11));
    end
  end

endmodule

bind cascade_timer_bank tmrb_checker #(.NUM(NUM), .AW(AW)) u_tmrb_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_wdata(bus_wdata), .bus_err(bus_err), .uflow(uflow),
  .mode_flat(mode_flat), .base_flat(base_flat), .cnt_flat(cnt_flat)
);

// File: tb/cascade_timer_bank_bench.sv
module cascade_timer_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  uflow;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  int  uf_cnt [4];
  logic [3:0] last_uf;

  always #4 clk = ~clk;

  cascade_timer_bank u_cascade_timer_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .uflow(uflow)
  );

  // {write, addr, size, wdata, expected err, expected read data}
  localparam int NV = 25;
  localparam logic [75:0] VEC [NV] = '{
    {1'b1, 8'h10, 2'd0, 32'h000000AB, 1'b0, 32'h00000000}, // 0  R6 stopped base write
    {1'b0, 8'h20, 2'd0, 32'h00000000, 1'b0, 32'h000000AB}, // 1  R9 counter mirrors base
    {1'b1, 8'h12, 2'd1, 32'h00003412, 1'b0, 32'h00000000}, // 2  R8 two-byte at timer 2
    {1'b0, 8'h10, 2'd2, 32'h00000000, 1'b0, 32'h341200AB}, // 3  R8 four-byte packing
    {1'b0, 8'h22, 2'd1, 32'h00000000, 1'b0, 32'h00003412}, // 4  R8 counter pair
    {1'b0, 8'h11, 2'd1, 32'h00000000, 1'b1, 32'h00000000}, // 5  R8 two-byte at timer 1
    {1'b1, 8'h13, 2'd1, 32'h0000FFFF, 1'b1, 32'h00000000}, // 6  R8 two-byte at timer 3
    {1'b0, 8'h12, 2'd2, 32'h00000000, 1'b1, 32'h00000000}, // 7  R8 four-byte off timer 0
    {1'b1, 8'h20, 2'd0, 32'h00000055, 1'b1, 32'h00000000}, // 8  R9 counter write
    {1'b0, 8'h20, 2'd0, 32'h00000000, 1'b0, 32'h000000AB}, // 9  R9 counter unchanged
    {1'b1, 8'h00, 2'd0, 32'h000000C0, 1'b1, 32'h00000000}, // 10 R3 enable plus load
    {1'b1, 8'h01, 2'd0, 32'h00000004, 1'b1, 32'h00000000}, // 11 R3 reserved bit
    {1'b1, 8'h00, 2'd0, 32'h00000003, 1'b1, 32'h00000000}, // 12 R4 timer 0 cascade
    {1'b0, 8'h00, 2'd2, 32'h00000000, 1'b0, 32'h00000000}, // 13 R3 modes untouched
    {1'b1, 8'h02, 2'd1, 32'h00000080, 1'b1, 32'h00000000}, // 14 R8 wide mode write
    {1'b0, 8'h30, 2'd0, 32'h00000000, 1'b1, 32'h00000000}, // 15 R11 unmapped group
    {1'b0, 8'h05, 2'd0, 32'h00000000, 1'b1, 32'h00000000}, // 16 R11 unmapped offset
    {1'b0, 8'h10, 2'd3, 32'h00000000, 1'b1, 32'h00000000}, // 17 R11 size code 3
    {1'b1, 8'h01, 2'd0, 32'h00000003, 1'b0, 32'h00000000}, // 18 R5 cascade, disabled
    {1'b1, 8'h00, 2'd0, 32'h00000080, 1'b1, 32'h00000000}, // 19 R5 start rejected
    {1'b0, 8'h00, 2'd1, 32'h00000000, 1'b0, 32'h00000300}, // 20 R5 head still off
    {1'b1, 8'h01, 2'd0, 32'h00000000, 1'b0, 32'h00000000}, // 21 R2 clear timer 1
    {1'b1, 8'h00, 2'd0, 32'h00000040, 1'b0, 32'h00000000}, // 22 R2 load bit alone
    {1'b0, 8'h00, 2'd0, 32'h00000000, 1'b0, 32'h00000040}, // 23 R2 mode readback
    {1'b1, 8'h00, 2'd0, 32'h00000000, 1'b0, 32'h00000000}  // 24 R2 clear timer 0
  };

  function automatic string vec_req(input int k);
    case (k)
      0:                    return "R6";
      1, 8, 9:              return "R9";
      10, 11, 13:           return "R3";
      12:                   return "R4";
      15, 16, 17:           return "R11";
      18, 19, 20:           return "R5";
      21, 22, 23, 24:       return "R2";
      default:              return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output logic e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    #1;
    rd = bus_rdata; e = bus_err;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr_ok(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] wd,
                       input string req);
    logic [31:0] rd; logic e;
    bus(1'b1, a, sz, wd, rd, e);
    check(e == 1'b0, req, "legal write flagged", {31'd0, e}, 32'd0);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] exp, input string req);
    logic [31:0] rd; logic e;
    bus(1'b0, a, sz, 32'd0, rd, e);
    check(e == 1'b0 && rd == exp, req, "read data", rd, exp);
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < 4; k++) uf_cnt[k] = 0;
    last_uf = '0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
      #1;
      tick = 1'b0;
      last_uf = uflow;
      for (int k = 0; k < 4; k++) uf_cnt[k] += int'(uflow[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        e;
    logic [75:0] v;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(uflow == 4'd0, "R1", "uflow after reset", {28'd0, uflow}, 32'd0);
    rd_chk(8'h00, 2'd2, 32'd0, "R1");
    rd_chk(8'h10, 2'd2, 32'd0, "R1");
    rd_chk(8'h20, 2'd2, 32'd0, "R1");

    // Register access table
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      bus(v[75], v[74:67], v[66:65], v[64:33], rd, e);
      check(e == v[32], vec_req(k), $sformatf("vector %0d err", k), {31'd0, e}, {31'd0, v[32]});
      if (!v[75] && !v[32])
        check(rd == v[31:0], vec_req(k), $sformatf("vector %0d data", k), rd, v[31:0]);
    end

    // R2 / R12 lone timer, base 3
    wr_ok(8'h10, 2'd0, 32'h03, "R2");
    wr_ok(8'h00, 2'd0, 32'h80, "R2");
    run_ticks(3);
    check(uf_cnt[0] == 1 && last_uf[0], "R2", "underflow on third tick", uf_cnt[0], 1);
    @(negedge clk);
    @(posedge clk);
    #1;
    check(uflow == 4'd0, "R12", "pulse lasts one cycle", {28'd0, uflow}, 32'd0);
    run_ticks(4);
    check(uf_cnt[0] == 1, "R2", "second period underflows", uf_cnt[0], 1);
    rd_chk(8'h20, 2'd0, 32'h02, "R2");

    // R6 base write while running
    wr_ok(8'h10, 2'd0, 32'h05, "R6");
    rd_chk(8'h20, 2'd0, 32'h02, "R6");
    rd_chk(8'h10, 2'd0, 32'h05, "R6");
    run_ticks(2);
    check(uf_cnt[0] == 1, "R6", "old count finishes", uf_cnt[0], 1);
    rd_chk(8'h20, 2'd0, 32'h05, "R6");

    // R10 stop and zero reload
    run_ticks(1);
    rd_chk(8'h20, 2'd0, 32'h04, "R10");
    wr_ok(8'h00, 2'd0, 32'h00, "R10");
    rd_chk(8'h20, 2'd0, 32'h05, "R10");
    run_ticks(3);
    check(uf_cnt[0] == 0, "R10", "stopped timer silent", uf_cnt[0], 0);
    rd_chk(8'h20, 2'd0, 32'h05, "R10");
    wr_ok(8'h10, 2'd0, 32'h00, "R10");
    wr_ok(8'h00, 2'd0, 32'h80, "R10");
    run_ticks(5);
    check(uf_cnt[0] == 0, "R10", "zero reload silent", uf_cnt[0], 0);
    rd_chk(8'h20, 2'd0, 32'h00, "R10");
    wr_ok(8'h00, 2'd0, 32'h00, "R10");

    // R7 16-bit chain, reload 0x0102
    wr_ok(8'h10, 2'd1, 32'h0102, "R7");
    wr_ok(8'h01, 2'd0, 32'h83, "R7");
    wr_ok(8'h00, 2'd0, 32'h80, "R7");
    run_ticks(3);
    rd_chk(8'h20, 2'd1, 32'h00FF, "R7");
    run_ticks(255);
    check(uf_cnt[0] == 0, "R7", "lower member silent", uf_cnt[0], 0);
    check(uf_cnt[1] == 1 && last_uf[1], "R7", "top pulses at end", uf_cnt[1], 1);
    rd_chk(8'h20, 2'd1, 32'h0102, "R7");
    wr_ok(8'h00, 2'd0, 32'h00, "R10");
    rd_chk(8'h20, 2'd0, 32'h02, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule